// File: doc/BRIEF.md
# GPIO Port Control Registers with Masked Writes

This block holds the control state for one port of eight general-purpose pins and sits on a simple 32-bit register bus. It keeps three writable registers: a per-pin ownership bit that puts the pin under GPIO control, a per-pin drive-enable bit, and a per-pin drive value. It also returns the pad inputs through a two-flop synchronizer. The pad drive-enable and drive-value lines come straight from these registers.

Each writable register can be reached at two addresses. The plain address replaces the whole register. The alias address changes only the pins that the write selects, so several agents can own different pins of one port and never need a read-modify-write. A read-only level view returns the driven value for pins that are driving and the synchronized input for the rest. Software sets the drive value before it sets the drive enable, and the pad then never drives a stale level. The port is one of several in a bank. Its address window moves with its index, so each port has its own 4-byte slot.

Top module: `gpio_port_regs`

## Requirements
- R1: After reset every writable register is 0 (pin not owned, not driving, value low), padOe and padOut are 0, and each register reads back 0.
- R2: A write to a plain address replaces all eight bits of its register with busWdata[7:0]. The plain offsets are ownership 0x00, drive enable 0x10 and drive value 0x20, each plus 4*PORT_INDEX. The upper data bits have no effect.
- R3: A write to the alias address (plain address + MASK_OFFSET, default 0x80) changes pin p only when busWdata[8+p] is 1, and sets it to busWdata[p]. Pins whose select bit is 0 keep their value.
- R4: A read returns its data and busRvalid one cycle after the request. A plain read and an alias read of the same register return its value in bits [7:0], and bits [31:8] read as 0.
- R5: The input register at offset 0x30 (+4*PORT_INDEX) returns padIn through two flip-flops. A read issued in the same cycle as a padIn change, or in the cycle after, returns the old value, and the read issued two cycles after it returns the new value. Writes to the input address and to its alias change no state.
- R6: padOe[p] is 1 only when both the ownership bit and the drive-enable bit of pin p are 1. padOut[p] is the drive-value bit gated by the ownership bit.
- R7: A read of the level view at 0x30 + MASK_OFFSET (+4*PORT_INDEX) returns, for each pin, the drive-value bit if padOe is 1 for that pin, and otherwise the synchronized input bit.
- R8: Writes to addresses outside this port's window change nothing. Reads there return 0, with busRvalid still set.
- R9: An alias write to one register leaves the other two unchanged. So writing the drive value and then setting the drive enable makes padOut correct in the cycle that padOe rises, and clearing a single ownership bit releases only that pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Bus request valid for this cycle |
| busWrite | input | 1 | 1 for a write, 0 for a read |
| busAddr | input | ADDR_W | Byte address |
| busWdata | input | DATA_W | Write data; the alias uses [15:8] as the pin select and [7:0] as the values |
| busRdata | output | DATA_W | Read data, registered |
| busRvalid | output | 1 | Read data valid, one cycle after the read request |
| padIn | input | PIN_COUNT | Asynchronous pad input levels |
| padOe | output | PIN_COUNT | Pad drive enable per pin |
| padOut | output | PIN_COUNT | Pad drive value per pin |

## Verification
The bench builds the block with eight pins and PORT_INDEX set to 2. The port's window therefore does not start at address zero, and writes aimed at port 0 show the address decode rejecting a neighbour's slot. With eight pins, all 256 select masks of the alias can be swept against a model state that changes after every write. The bench also sweeps all 256 plain values of the drive-enable register while ownership is clear, which shows that the pad stays released. The two-stage input delay is counted one read at a time around a padIn change.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  // Register offsets inside a port window (before the port index is added).
  localparam int OFS_CNF = 'h00;
  localparam int OFS_OE  = 'h10;
  localparam int OFS_OUT = 'h20;
  localparam int OFS_IN  = 'h30;

  typedef enum logic [2:0] {
    RD_NONE  = 3'd0,
    RD_CNF   = 3'd1,
    RD_OE    = 3'd2,
    RD_OUT   = 3'd3,
    RD_IN    = 3'd4,
    RD_LEVEL = 3'd5
  } rd_src_e;

  // Strobes from the decoder to the datapath.
  typedef struct packed {
    logic    wrCnf;
    logic    wrOe;
    logic    wrOut;
    logic    useMask;
    logic    rdEn;
    rd_src_e rdSrc;
  } gp_strobe_t;

endpackage

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int PORT_INDEX  = 0,
  parameter int PORT_STRIDE = 4,
  parameter int MASK_OFFSET = 'h80
) (
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output gp_strobe_t        strobe
);

  localparam int BASE = PORT_INDEX * PORT_STRIDE;
  localparam logic [ADDR_W-1:0] A_CNF  = ADDR_W'(BASE + OFS_CNF);
  localparam logic [ADDR_W-1:0] A_OE   = ADDR_W'(BASE + OFS_OE);
  localparam logic [ADDR_W-1:0] A_OUT  = ADDR_W'(BASE + OFS_OUT);
  localparam logic [ADDR_W-1:0] A_IN   = ADDR_W'(BASE + OFS_IN);
  localparam logic [ADDR_W-1:0] M_CNF  = ADDR_W'(BASE + MASK_OFFSET + OFS_CNF);
  localparam logic [ADDR_W-1:0] M_OE   = ADDR_W'(BASE + MASK_OFFSET + OFS_OE);
  localparam logic [ADDR_W-1:0] M_OUT  = ADDR_W'(BASE + MASK_OFFSET + OFS_OUT);
  localparam logic [ADDR_W-1:0] M_LVL  = ADDR_W'(BASE + MASK_OFFSET + OFS_IN);

  logic hitCnf, hitOe, hitOut, isAlias;
  rd_src_e src;

  always_comb begin
    hitCnf  = (busAddr == A_CNF) || (busAddr == M_CNF);
    hitOe   = (busAddr == A_OE)  || (busAddr == M_OE);
    hitOut  = (busAddr == A_OUT) || (busAddr == M_OUT);
    isAlias = (busAddr == M_CNF) || (busAddr == M_OE) || (busAddr == M_OUT);

    unique case (1'b1)
      hitCnf:            src = RD_CNF;
      hitOe:             src = RD_OE;
      hitOut:            src = RD_OUT;
      busAddr == A_IN:   src = RD_IN;
      busAddr == M_LVL:  src = RD_LEVEL;
      default:           src = RD_NONE;
    endcase
  end

  always_comb begin
    strobe.wrCnf   = busSel && busWrite && hitCnf;
    strobe.wrOe    = busSel && busWrite && hitOe;
    strobe.wrOut   = busSel && busWrite && hitOut;
    strobe.useMask = isAlias;
    strobe.rdEn    = busSel && !busWrite;
    strobe.rdSrc   = (busSel && !busWrite) ? src : RD_NONE;
  end

endmodule

// File: rtl/gpio_port_dp.sv
module gpio_port_dp
  import gpio_port_pkg::*;
#(
  parameter int PIN_COUNT   = 8,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  gp_strobe_t           strobe,
  input  logic [DATA_W-1:0]    busWdata,
  input  logic [PIN_COUNT-1:0] padIn,
  output logic [PIN_COUNT-1:0] cnfVal,
  output logic [PIN_COUNT-1:0] oeVal,
  output logic [PIN_COUNT-1:0] outVal,
  output logic [PIN_COUNT-1:0] inVal,
  output logic [PIN_COUNT-1:0] padOe,
  output logic [PIN_COUNT-1:0] padOut,
  output logic [DATA_W-1:0]    busRdata,
  output logic                 busRvalid
);

  localparam int NREG = 3;  // 0 ownership, 1 drive enable, 2 drive value

  logic [NREG-1:0][PIN_COUNT-1:0] ctlQ;
  logic [NREG-1:0][PIN_COUNT-1:0] ctlD;
  logic [NREG-1:0]                wrEn;
  logic [SYNC_STAGES-1:0][PIN_COUNT-1:0] syncQ;
  logic [PIN_COUNT-1:0] levelView;
  logic [PIN_COUNT-1:0] rdSel;

  assign wrEn = {strobe.wrOut, strobe.wrOe, strobe.wrCnf};

  // Per-pin merge: the alias keeps unselected pins, the plain address takes all.
  for (genvar r = 0; r < NREG; r++) begin : g_reg
    for (genvar p = 0; p < PIN_COUNT; p++) begin : g_pin
      assign ctlD[r][p] = strobe.useMask
                          ? (busWdata[PIN_COUNT+p] ? busWdata[p] : ctlQ[r][p])
                          : busWdata[p];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctlQ <= '0;
    end else begin
      for (int r = 0; r < NREG; r++) begin
        if (wrEn[r]) ctlQ[r] <= ctlD[r];
      end
    end
  end

  // Input synchronizer chain.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= '0;
    end else begin
      syncQ[0] <= padIn;
      for (int s = 1; s < SYNC_STAGES; s++) syncQ[s] <= syncQ[s-1];
    end
  end

  assign cnfVal = ctlQ[0];
  assign oeVal  = ctlQ[1];
  assign outVal = ctlQ[2];
  assign inVal  = syncQ[SYNC_STAGES-1];

  assign padOe     = cnfVal & oeVal;
  assign padOut    = cnfVal & outVal;
  assign levelView = (padOe & outVal) | (~padOe & inVal);

  always_comb begin
    unique case (strobe.rdSrc)
      RD_CNF:   rdSel = cnfVal;
      RD_OE:    rdSel = oeVal;
      RD_OUT:   rdSel = outVal;
      RD_IN:    rdSel = inVal;
      RD_LEVEL: rdSel = levelView;
      default:  rdSel = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busRdata  <= '0;
      busRvalid <= 1'b0;
    end else begin
      busRvalid <= strobe.rdEn;
      busRdata  <= strobe.rdEn ? DATA_W'(rdSel) : '0;
    end
  end

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int PIN_COUNT   = 8,
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 12,
  parameter int PORT_INDEX  = 0,
  parameter int PORT_STRIDE = 4,
  parameter int MASK_OFFSET = 'h80,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busSel,
  input  logic                 busWrite,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [DATA_W-1:0]    busWdata,
  output logic [DATA_W-1:0]    busRdata,
  output logic                 busRvalid,
  input  logic [PIN_COUNT-1:0] padIn,
  output logic [PIN_COUNT-1:0] padOe,
  output logic [PIN_COUNT-1:0] padOut
);

  gp_strobe_t strobe;
  logic [PIN_COUNT-1:0] cnfVal, oeVal, outVal, inVal;

  gpio_port_ctrl #(
    .ADDR_W(ADDR_W), .PORT_INDEX(PORT_INDEX),
    .PORT_STRIDE(PORT_STRIDE), .MASK_OFFSET(MASK_OFFSET)
  ) ctrl_i (
    .busSel(busSel), .busWrite(busWrite), .busAddr(busAddr), .strobe(strobe)
  );

  gpio_port_dp #(
    .PIN_COUNT(PIN_COUNT), .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busWdata(busWdata),
    .padIn(padIn), .cnfVal(cnfVal), .oeVal(oeVal), .outVal(outVal),
    .inVal(inVal), .padOe(padOe), .padOut(padOut),
    .busRdata(busRdata), .busRvalid(busRvalid)
  );

endmodule

// File: rtl/gpio_port_regs_chk.sv
module gpio_port_regs_chk
  import gpio_port_pkg::*;
#(
  parameter int PIN_COUNT   = 8,
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 12,
  parameter int PORT_INDEX  = 0,
  parameter int PORT_STRIDE = 4,
  parameter int MASK_OFFSET = 'h80,
  parameter int SYNC_STAGES = 2
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 busSel,
  input logic                 busWrite,
  input logic [ADDR_W-1:0]    busAddr,
  input logic [DATA_W-1:0]    busWdata,
  input logic [DATA_W-1:0]    busRdata,
  input logic                 busRvalid,
  input logic [PIN_COUNT-1:0] padIn,
  input logic [PIN_COUNT-1:0] cnfVal,
  input logic [PIN_COUNT-1:0] oeVal,
  input logic [PIN_COUNT-1:0] outVal,
  input logic [PIN_COUNT-1:0] inVal
);

  localparam int BASE = PORT_INDEX * PORT_STRIDE;
  localparam logic [ADDR_W-1:0] P_OE  = ADDR_W'(BASE + OFS_OE);
  localparam logic [ADDR_W-1:0] M_OUT = ADDR_W'(BASE + MASK_OFFSET + OFS_OUT);

  logic isWr, isRd;
  assign isWr = busSel && busWrite;
  assign isRd = busSel && !busWrite;

  logic [1:0] sinceRst;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sinceRst <= '0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end

  assert_plain_oe_R2: assert property (@(posedge clk) disable iff (!rstN)
    (isWr && busAddr == P_OE) |=> oeVal == $past(busWdata[PIN_COUNT-1:0]));

  assert_masked_out_R3: assert property (@(posedge clk) disable iff (!rstN)
    (isWr && busAddr == M_OUT) |=>
      outVal == (($past(outVal) & ~$past(busWdata[2*PIN_COUNT-1:PIN_COUNT])) |
                 ($past(busWdata[PIN_COUNT-1:0]) & $past(busWdata[2*PIN_COUNT-1:PIN_COUNT]))));

  assert_rvalid_R4: assert property (@(posedge clk) disable iff (!rstN)
    isRd |=> busRvalid);

  assert_no_rvalid_R4: assert property (@(posedge clk) disable iff (!rstN)
    !isRd |=> !busRvalid);

  assert_upper_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    busRvalid |-> busRdata[DATA_W-1:PIN_COUNT] == '0);

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !isWr |=> ($stable(cnfVal) && $stable(oeVal) && $stable(outVal)));

  if (SYNC_STAGES == 2) begin : g_sync_chk
    assert_sync_delay_R5: assert property (@(posedge clk) disable iff (!rstN)
      (sinceRst >= 2'd2) |-> inVal == $past(padIn, 2));
  end

endmodule

bind gpio_port_regs gpio_port_regs_chk #(
  .PIN_COUNT(PIN_COUNT), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
  .PORT_INDEX(PORT_INDEX), .PORT_STRIDE(PORT_STRIDE),
  .MASK_OFFSET(MASK_OFFSET), .SYNC_STAGES(SYNC_STAGES)
) chk_i (
  .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
  .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
  .busRvalid(busRvalid), .padIn(padIn), .cnfVal(cnfVal), .oeVal(oeVal),
  .outVal(outVal), .inVal(inVal)
);

// File: tb/gpio_port_regs_tb_top.sv
module gpio_port_regs_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int N  = 8;
  localparam int DW = 32;
  localparam int AW = 12;
  localparam int PIDX = 2;
  localparam int MOFS = 'h80;
  localparam int BASE = PIDX * 4;

  localparam logic [AW-1:0] A_CNF = AW'(BASE + 'h00);
  localparam logic [AW-1:0] A_OE  = AW'(BASE + 'h10);
  localparam logic [AW-1:0] A_OUT = AW'(BASE + 'h20);
  localparam logic [AW-1:0] A_IN  = AW'(BASE + 'h30);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busSel = 1'b0, busWrite = 1'b0;
  logic [AW-1:0] busAddr = '0;
  logic [DW-1:0] busWdata = '0;
  logic [DW-1:0] busRdata;
  logic busRvalid;
  logic [N-1:0] padIn = '0;
  logic [N-1:0] padOe, padOut;

  int nTests = 0;
  int nFail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_port_regs #(
    .PIN_COUNT(N), .DATA_W(DW), .ADDR_W(AW), .PORT_INDEX(PIDX),
    .PORT_STRIDE(4), .MASK_OFFSET(MOFS), .SYNC_STAGES(2)
  ) dut_i (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .busRvalid(busRvalid), .padIn(padIn), .padOe(padOe), .padOut(padOut)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0;
  endtask

  task automatic busRd(input logic [AW-1:0] a, output logic [DW-1:0] d, output logic v);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b0; busAddr = a;
    @(negedge clk);
    busSel = 1'b0;
    d = busRdata; v = busRvalid;
  endtask

  task automatic rdCheck(input logic [AW-1:0] a, input logic [7:0] exp, input string req);
    logic [DW-1:0] d;
    logic v;
    busRd(a, d, v);
    check(v && d == {24'h0, exp}, req, d, {24'h0, exp});
  endtask

  function automatic logic [7:0] mergeMask(input logic [7:0] cur, input logic [7:0] m,
                                           input logic [7:0] v);
    return (cur & ~m) | (v & m);
  endfunction

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nTests++; nFail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
    finishRun();
  end

  initial begin
    logic [DW-1:0] d;
    logic v;
    logic [7:0] model;
    logic [7:0] prevOut, prevOe;

    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    check(padOe == 0 && padOut == 0, "R1 pads", {padOe, padOut}, 0);
    rdCheck(A_CNF, 8'h00, "R1 cnf");
    rdCheck(A_OE,  8'h00, "R1 oe");
    rdCheck(A_OUT, 8'h00, "R1 out");

    // R2 / R6: all plain values into drive enable, ownership clear keeps pad released
    for (int i = 0; i < 256; i++) begin
      busWr(A_OE, {24'hA5C3E1, 8'(i)});
      check(padOe == 0, "R6 released", padOe, 0);
      rdCheck(A_OE, 8'(i), "R2 oe sweep");
    end
    busWr(A_CNF, 32'hFFFF_FF3C);
    rdCheck(A_CNF, 8'h3C, "R2 cnf plain");

    // R3: every select mask on the drive-value alias
    busWr(A_OUT, 32'h0000_0000);
    model = 8'h00;
    for (int m = 0; m < 256; m++) begin
      logic [7:0] val;
      val = 8'((m * 37 + 11) % 256);
      busWr(A_OUT + AW'(MOFS), {16'h0, 8'(m), val});
      model = mergeMask(model, 8'(m), val);
      rdCheck(A_OUT, model, "R3 out alias sweep");
    end
    // R3 on ownership alias
    busWr(A_CNF + AW'(MOFS), {16'h0, 8'hF0, 8'h5A});
    rdCheck(A_CNF, mergeMask(8'h3C, 8'hF0, 8'h5A), "R3 cnf alias");

    // R4: alias read equals plain read, upper bits zero
    busWr(A_OE, 32'hFFFF_FF5A);
    rdCheck(A_OE + AW'(MOFS), 8'h5A, "R4 alias read");
    busRd(A_OE, d, v);
    check(v && d == 32'h5A, "R4 plain read", d, 32'h5A);

    // R6 / R7: pad gating and level view
    busWr(A_CNF, 32'hF0);
    busWr(A_OE,  32'hCC);
    busWr(A_OUT, 32'hAA);
    check(padOe == 8'hC0, "R6 padOe", padOe, 8'hC0);
    check(padOut == 8'hA0, "R6 padOut", padOut, 8'hA0);
    @(negedge clk); padIn = 8'h0F;
    repeat (3) @(negedge clk);
    rdCheck(A_IN + AW'(MOFS), 8'h8F, "R7 level view");
    rdCheck(A_IN, 8'h0F, "R5 input settled");

    // R5: synchronizer latency, counted read by read
    @(negedge clk); padIn = 8'hE1;
    busSel = 1'b1; busWrite = 1'b0; busAddr = A_IN;
    @(negedge clk); d = busRdata;
    check(busRvalid && d == 32'h0F, "R5 read same cycle", d, 32'h0F);
    @(negedge clk); d = busRdata;
    check(busRvalid && d == 32'h0F, "R5 read one later", d, 32'h0F);
    @(negedge clk); d = busRdata; busSel = 1'b0;
    check(busRvalid && d == 32'hE1, "R5 read two later", d, 32'hE1);

    // R5: writes to input address and alias change nothing
    busWr(A_IN, 32'h0000_FF00);
    busWr(A_IN + AW'(MOFS), 32'h0000_FFFF);
    rdCheck(A_IN, 8'hE1, "R5 input write ignored");
    rdCheck(A_CNF, 8'hF0, "R5 cnf untouched");
    rdCheck(A_OE, 8'hCC, "R5 oe untouched");
    rdCheck(A_OUT, 8'hAA, "R5 out untouched");

    // R8: another port's slot and unmapped addresses
    busWr(AW'('h00), 32'h0000_FFFF);
    busWr(AW'('h10 + MOFS), 32'h0000_FFFF);
    busWr(AW'('h24), 32'h0000_0000);
    rdCheck(A_CNF, 8'hF0, "R8 cnf untouched");
    rdCheck(A_OE, 8'hCC, "R8 oe untouched");
    rdCheck(A_OUT, 8'hAA, "R8 out untouched");
    rdCheck(AW'('h20), 8'h00, "R8 foreign read zero");
    rdCheck(AW'('h3FC), 8'h00, "R8 unmapped read zero");

    // R9: value first, then enable; then release one pin
    prevOe = 8'hCC;
    busWr(A_OUT + AW'(MOFS), {16'h0, 8'h10, 8'h10});
    check(padOe[4] == 1'b0 && padOut[4] == 1'b1, "R9 value before enable",
          {padOe, padOut}, {8'hC0, 8'hB0});
    rdCheck(A_OE, prevOe, "R9 oe kept on out alias");
    prevOut = 8'hBA;
    busWr(A_OE + AW'(MOFS), {16'h0, 8'h10, 8'h10});
    check(padOe == 8'hD0 && padOut == 8'hB0, "R9 enable with correct value",
          {padOe, padOut}, {8'hD0, 8'hB0});
    rdCheck(A_OUT, prevOut, "R9 out kept on oe alias");
    busWr(A_CNF + AW'(MOFS), {16'h0, 8'h40, 8'h00});
    check(padOe == 8'h90 && padOut == 8'hB0, "R9 release one pin",
          {padOe, padOut}, {8'h90, 8'hB0});

    finishRun();
  end

endmodule